// File: doc/BRIEF.md
# Errored-Second Interrupt Status Register

This block is the interrupt status byte of a line framer's receive side. It counts the receive clock down to a one-second interval. At each expiry it raises a timer status bit. At the same moment it raises an errored-second bit if any enabled line alarm pulsed during the interval just ended. A third status bit reports a change in the line-loopback detectors or, in the alternative mode, a change of the pseudo-random pattern synchroniser lock.

Software reads the byte through a read strobe, and every bit clears on that read. A per-bit mask controls which latched bits drive the interrupt line and the global summary bit. A visibility mode lets masked conditions still latch for polling, without raising the interrupt or the summary.

Top module: `es_int_status`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status byte, `irq` and `summary` all clear to 0.
- R2: Status bit 6 (timer) sets once every `SEC_CYCLES` clock cycles. The first setting follows the `SEC_CYCLES`-th edge after reset is released. Bits 5 to 1 always read 0.
- R3: Status bit 7 (errored second) sets at a timer expiry if any `err_ev` bit whose `err_en` bit is 1 was high in any cycle of that interval, including the expiry cycle. The `err_ev`/`err_en` positions are: 0 frame alignment loss, 1 framing error, 2 CRC error, 3 AIS, 4 loss of signal, 5 code violation, 6 slip.
- R4: An `err_ev` pulse whose `err_en` bit is 0 does not contribute to bit 7.
- R5: The error accumulation restarts after each expiry. Events from an earlier interval never set bit 7 at a later expiry.
- R6: With `prbs_mode` = 0, status bit 0 sets in the cycle after `lb_act_det` or `lb_deact_det` changes level, in either direction.
- R7: With `prbs_mode` = 1, status bit 0 sets after any change of `prbs_sync`. The loopback detector inputs are then ignored.
- R8: A cycle with `rd_stb` = 1 clears every status bit at the next edge.
- R9: A status event in the same cycle as `rd_stb` leaves its bit set after the read.
- R10: With `vis_all` = 0, a status event whose `irq_mask` bit is 1 (masked) does not latch.
- R11: With `vis_all` = 1, masked events latch in the status byte but drive neither `irq` nor `summary`.
- R12: `irq` and `summary` are 1 exactly when some latched status bit has its `irq_mask` bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-derived clock |
| rst_n | input | 1 | Synchronous reset, active low |
| err_ev | input | 7 | Line alarm event pulses (positions in R3) |
| err_en | input | 7 | Errored-second enable per event |
| lb_act_det | input | 1 | Loopback activate pattern detected state |
| lb_deact_det | input | 1 | Loopback deactivate pattern detected state |
| prbs_sync | input | 1 | Pattern synchroniser lock state |
| prbs_mode | input | 1 | Selects the pattern synchroniser as the source of bit 0 |
| irq_mask | input | 8 | Per-bit interrupt mask, 1 = masked |
| vis_all | input | 1 | Latch masked statuses as well |
| rd_stb | input | 1 | Status register read strobe |
| status | output | 8 | Latched status byte |
| irq | output | 1 | Interrupt line, active high |
| summary | output | 1 | Global interrupt summary bit |

## Verification
A register read can land in the same cycle as a new status event. That event can be the timer expiry with its errored-second result, or a loopback level change. The bench steers a read onto such a cycle on purpose, and random reads also hit expiries at a rate of about one in eight. A cycle-accurate bench model, built from the requirements, predicts that the new bit survives the read while older bits clear. Any difference is flagged against R9 or R8.

// File: rtl/es_pkg.sv
// Shared bit positions and sizes of the errored-second status register.
// Assumes an 8-bit status byte; positions are fixed by the software view.
package es_pkg;
    localparam int STAT_W   = 8;
    localparam int NUM_EV   = 7;
    localparam int ES_BIT   = 7;
    localparam int TICK_BIT = 6;
    localparam int LBC_BIT  = 0;
    localparam logic [STAT_W-1:0] USED_MASK =
        STAT_W'((1 << ES_BIT) | (1 << TICK_BIT) | (1 << LBC_BIT));
endpackage

// File: rtl/es_sec_timer.sv
// One-second interval divider: pulses tick for one cycle every SEC_CYCLES
// clocks. Assumes SEC_CYCLES >= 2 and a free-running receive clock.
module es_sec_timer #(
    parameter int SEC_CYCLES = 2048000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(SEC_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(SEC_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Detect the final count of the interval.
    assign tick = (cnt_q == LAST);

    // Advance the divider, wrapping at the end of each second.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R2: an expiry is never followed directly by another.
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/es_err_accum.sv
// Errored-second accumulator: ORs enabled event pulses across one interval
// and reports the result on the expiry cycle, then restarts.
// Assumes tick is a single-cycle pulse from the interval timer.
module es_err_accum #(
    parameter int NEV = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [NEV-1:0] ev,
    input  logic [NEV-1:0] en,
    output logic           es_set
);
    logic acc_q;
    logic hit;

    // Any enabled event in the present cycle.
    assign hit    = |(ev & en);
    // The result of the closing interval includes the expiry cycle itself.
    assign es_set = tick & (acc_q | hit);

    // Hold the interval's error memory; clear it once the result is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= 1'b0;
        else if (tick) acc_q <= 1'b0;
        else           acc_q <= acc_q | hit;
    end
endmodule

// File: rtl/es_lbk_change.sv
// Status-change detector for the loopback detectors or, in pattern mode,
// the pattern synchroniser lock. Assumes its inputs are already synchronous.
module es_lbk_change (
    input  logic clk,
    input  logic rst_n,
    input  logic prbs_mode,
    input  logic act_det,
    input  logic deact_det,
    input  logic sync_in,
    output logic change
);
    logic act_q, deact_q, sync_q;

    // Compare each source with its previous level; the mode picks one.
    always_comb begin
        if (prbs_mode) change = (sync_in != sync_q);
        else           change = (act_det != act_q) || (deact_det != deact_q);
    end

    // Track all source levels in every mode so a mode switch sees history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            deact_q <= 1'b0;
            sync_q  <= 1'b0;
        end else begin
            act_q   <= act_det;
            deact_q <= deact_det;
            sync_q  <= sync_in;
        end
    end

    // R7: in pattern mode the loopback detectors cannot raise a change.
    p_mode_ignores_lb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && prbs_mode && $stable(sync_in)) |-> !change);
endmodule

// File: rtl/es_int_status.sv
// Interrupt status byte with clear-on-read bits: errored second (7),
// second timer (6) and loopback/pattern status change (0).
// Assumes one read strobe cycle per register read.
module es_int_status
    import es_pkg::*;
#(
    parameter int SEC_CYCLES = 2048000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] err_ev,
    input  logic [NUM_EV-1:0] err_en,
    input  logic              lb_act_det,
    input  logic              lb_deact_det,
    input  logic              prbs_sync,
    input  logic              prbs_mode,
    input  logic [STAT_W-1:0] irq_mask,
    input  logic              vis_all,
    input  logic              rd_stb,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic              summary
);
    logic              tick, es_set, lbc_chg;
    logic [STAT_W-1:0] raw, latch_ok, st_q, st_d;

    es_sec_timer #(.SEC_CYCLES(SEC_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    es_err_accum #(.NEV(NUM_EV)) u_accum (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ev(err_ev), .en(err_en), .es_set(es_set));

    es_lbk_change u_lbk (
        .clk(clk), .rst_n(rst_n), .prbs_mode(prbs_mode),
        .act_det(lb_act_det), .deact_det(lb_deact_det),
        .sync_in(prbs_sync), .change(lbc_chg));

    // Gather this cycle's events and decide which may latch.
    always_comb begin
        raw           = '0;
        raw[ES_BIT]   = es_set;
        raw[TICK_BIT] = tick;
        raw[LBC_BIT]  = lbc_chg;
        latch_ok      = {STAT_W{vis_all}} | ~irq_mask;
        st_d          = (rd_stb ? '0 : st_q) | (raw & latch_ok);
    end

    // Status byte storage with clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status  = st_q;
    assign irq     = |(st_q & ~irq_mask);
    assign summary = irq;

    // R2: unassigned positions never latch.
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q & ~USED_MASK) == '0);
    // R3: an errored second is reported only on a timer expiry.
    p_es_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        es_set |-> tick);
    // R8: a read with no new event empties the register.
    p_clear_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && raw == '0) |=> (status == '0));
    // R9: a timer expiry coinciding with a read is kept.
    p_keep_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && tick && (vis_all || !irq_mask[TICK_BIT])) |=> status[TICK_BIT]);
    // R10: a masked bit stays clear when visibility is off.
    p_no_latch_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!vis_all && irq_mask[LBC_BIT] && !status[LBC_BIT]) |=> !status[LBC_BIT]);
endmodule

// File: tb/es_int_status_tb.sv
module es_int_status_tb;
    localparam int SEC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] ev = '0, en = 7'h7F;
    logic       act = 1'b0, deact = 1'b0, prbs = 1'b0, mode = 1'b0;
    logic [7:0] mask = '0;
    logic       vis = 1'b0, rd = 1'b0;
    logic [7:0] status;
    logic       irq, summary;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // bench model state
    int         m_cnt = 0;
    logic       m_acc = 1'b0, m_pa = 1'b0, m_pd = 1'b0, m_pp = 1'b0;
    logic [7:0] m_st = '0;

    always #2.5 clk = ~clk;

    es_int_status #(.SEC_CYCLES(SEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .err_ev(ev), .err_en(en),
        .lb_act_det(act), .lb_deact_det(deact), .prbs_sync(prbs),
        .prbs_mode(mode), .irq_mask(mask), .vis_all(vis), .rd_stb(rd),
        .status(status), .irq(irq), .summary(summary));

    function automatic logic exp_irq(input logic [7:0] st, input logic [7:0] mk);
        return |(st & ~mk);
    endfunction

    task automatic check8(input string tag, input logic [7:0] act_v, input logic [7:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
        end
    endtask

    task automatic compare(input string tag);
        check8({tag, " status"}, status, m_st);
        check8({tag, " irq"}, {7'b0, irq}, {7'b0, exp_irq(m_st, mask)});
        check8({tag, " summary"}, {7'b0, summary}, {7'b0, exp_irq(m_st, mask)});
    endtask

    // One clock: predict from requirements, let the edge pass, compare.
    task automatic cyc(input string tag);
        logic t, hit, es, lbc;
        logic [7:0] raw, ok, nst;
        t   = (m_cnt == SEC - 1);
        hit = |(ev & en);
        es  = t && (m_acc || hit);
        lbc = mode ? (prbs != m_pp) : ((act != m_pa) || (deact != m_pd));
        raw = 8'h00; raw[7] = es; raw[6] = t; raw[0] = lbc;
        ok  = {8{vis}} | ~mask;
        nst = (rd ? 8'h00 : m_st) | (raw & ok);
        @(posedge clk); #1;
        m_cnt = t ? 0 : m_cnt + 1;
        m_acc = t ? 1'b0 : (m_acc || hit);
        m_pa = act; m_pd = deact; m_pp = prbs; m_st = nst;
        compare(tag);
        @(negedge clk);
    endtask

    task automatic run_to_tick(input string tag);
        bit t;
        forever begin
            t = (m_cnt == SEC - 1);
            cyc(tag);
            if (t) break;
        end
    endtask

    task automatic do_read(input string tag);
        rd = 1'b1; cyc(tag);
        rd = 1'b0; cyc(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1: reset state
        check8("R1 status", status, 8'h00);
        check8("R1 irq", {7'b0, irq}, 8'h00);
        check8("R1 summary", {7'b0, summary}, 8'h00);
        rst_n = 1'b1;

        run_to_tick("R2 first expiry");
        do_read("R8 read clears");

        ev[2] = 1'b1; cyc("R3 crc pulse"); ev[2] = 1'b0;
        run_to_tick("R3 errored second");
        do_read("R8 read clears");

        en = 7'h7F & ~7'h10;
        ev[4] = 1'b1; cyc("R4 disabled los"); ev[4] = 1'b0;
        run_to_tick("R4 disabled source");
        en = 7'h7F;
        do_read("R8 read clears");

        ev[0] = 1'b1; cyc("R5 event"); ev[0] = 1'b0;
        run_to_tick("R5 first interval");
        do_read("R5 clear");
        run_to_tick("R5 clean interval");
        do_read("R5 clear");

        act = 1'b1; cyc("R6 activate enter");
        do_read("R6 read");
        deact = 1'b1; cyc("R6 deactivate enter");
        act = 1'b0; cyc("R6 activate leave");
        do_read("R6 read");

        mode = 1'b1;
        act = 1'b1; cyc("R7 lb ignored"); cyc("R7 lb ignored");
        prbs = 1'b1; cyc("R7 sync gain");
        do_read("R7 read");
        prbs = 1'b0; cyc("R7 sync loss");
        mode = 1'b0; act = 1'b0; cyc("R6 back to mode 0");

        // R9: change and read in the same cycle
        deact = 1'b0; cyc("R9 set");
        act = 1'b1; rd = 1'b1; cyc("R9 event with read");
        rd = 1'b0; cyc("R9 kept");
        while (m_cnt != SEC - 1) cyc("R9 align");
        rd = 1'b1; ev[1] = 1'b1; cyc("R9 expiry with read");
        rd = 1'b0; ev[1] = 1'b0; cyc("R9 kept expiry");
        do_read("R8 read clears");

        mask = 8'h01; vis = 1'b0;
        act = 1'b0; cyc("R10 masked no latch"); cyc("R10 masked no latch");
        vis = 1'b1;
        act = 1'b1; cyc("R11 masked latches"); cyc("R11 no irq");
        mask = 8'h00; cyc("R12 unmask raises irq");
        vis = 1'b0;
        do_read("R8 read clears");

        for (int i = 0; i < 3000; i++) begin
            ev   = 7'(($urandom % 16 == 0) ? (1 << ($urandom % 7)) : 0);
            if ($urandom % 64 == 0) en = 7'($urandom);
            if ($urandom % 32 == 0) mask = 8'($urandom);
            if ($urandom % 64 == 0) vis = 1'($urandom);
            if ($urandom % 128 == 0) mode = ~mode;
            if ($urandom % 20 == 0) act = ~act;
            if ($urandom % 20 == 0) deact = ~deact;
            if ($urandom % 20 == 0) prbs = ~prbs;
            rd = ($urandom % 8 == 0);
            cyc("R12 random (R2 R3 R6 R7 R9)");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule